// File: doc/BRIEF.md
# Unlock-Cycle Flash Erase and Program Sequencer

This block erases one sector of a byte-wide parallel flash, or programs it byte by byte, through the flash's unlock-cycle command protocol. Before every command, it writes a fixed pair of unlock cycles at two magic offsets. After each command write, it leaves the bus quiet for a programmable settling gap. It then watches for the end of the embedded operation by reading the sector base twice in a row. The operation is over once the two reads return the same value, which means the toggling status bit has stopped.

An operation starts with a one-cycle `start` pulse, and `modeProgram` selects erase or program. While the operation runs, the block holds `busy` high. When it ends, the block writes the flash reset command and waits one gap. If no timeout occurred, it then reads the whole region back and checks it. It ends with a one-cycle `done` pulse. Bytes to be programmed come from an external source buffer, addressed by the byte index. `error` and `errCode` report a poll timeout or a verify mismatch and hold until the next start.

Top module: `unlock_flash_seq`

## Requirements
- R1: Every command begins with two unlock writes: 0xAA to flash address 0x555, then 0x55 to address 0x2AA. The first bus cycle after `start` is accepted is the 0xAA write.
- R2: An erase (`modeProgram`=0) writes, after the unlock pair, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and then 0x30 to sector base address 0.
- R3: A program (`modeProgram`=1) repeats, for each byte index 0 to REGION_BYTES-1 in turn, the unlock pair, 0xA0 to 0x555, and then `srcData` (fetched at `srcAddr` = index) to flash address = index.
- R4: Every write on the flash bus is followed by GAP_CYCLES clocks in which neither `flashWe` nor `flashRe` is asserted.
- R5: Completion is polled with pairs of reads of address 0 on two consecutive clocks. A pair whose two values are equal ends the wait. At most POLL_LIMIT pairs are made per wait, and an equal pair in the last allowed slot counts as success.
- R6: If POLL_LIMIT pairs in a row differ, the operation ends with `errCode`=1 (timeout). During a program, no further byte is written, and no read-back is made.
- R7: Every operation, including one that timed out, issues exactly one write of 0xF0 to address 0 after its last command.
- R8: Without a timeout, after the reset write the block reads addresses 0 to REGION_BYTES-1. It expects 0xFF after an erase and `srcData` after a program. A mismatch ends the operation with `errCode`=2.
- R9: While `rstN` is low and after it is released, `busy`, `done`, `error`, `flashWe` and `flashRe` are 0 and `errCode` is 0.
- R10: `busy` rises on the clock after an accepted `start` and stays high until the cycle after `done`. `done` is a single-cycle pulse. `error` equals (`errCode`!=0) and holds until the next accepted start. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| modeProgram | input | 1 | 1 = program region, 0 = erase sector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Last operation failed |
| errCode | output | 2 | 0 none, 1 poll timeout, 2 verify mismatch |
| flashAddr | output | ADDR_W | Flash byte address |
| flashWrData | output | 8 | Flash write data |
| flashWe | output | 1 | Flash write cycle |
| flashRe | output | 1 | Flash read cycle, data sampled same clock |
| flashRdData | input | 8 | Flash read data |
| srcAddr | output | IDX_W | Source buffer byte index |
| srcData | input | 8 | Source byte at srcAddr |

## Verification
The poll-limit check and the end of the toggle condition can fall on the same read pair. On that last allowed pair, the comparison finds equal values at the moment the pair counter reaches its limit. The bench's flash model stays busy for a set number of reads. With 2·POLL_LIMIT−2 busy reads, the first equal pair is exactly the last permitted one, and the operation must succeed with `errCode`=0 and a full read-back. With 2·POLL_LIMIT busy reads, the same final pair still differs, and the result must be a timeout with no read-back. Both cases are run as erases and, for the success case, as a program where every byte meets the limit.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_POLL_A,
    ST_POLL_B,
    ST_RST_CMD,
    ST_RST_GAP,
    ST_VERIFY,
    ST_FINISH
  } seqState_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_VERIFY  = 2'd2
  } errCode_t;

  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic cmdClr;
    logic cmdInc;
    logic gapLoad;
    logic pollClr;
    logic pollInc;
    logic capFirst;
  } dpStrobe_t;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_ERASE_PRE = 8'h80;
  localparam logic [7:0] CMD_ERASE_GO = 8'h30;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_RESET = 8'hF0;

endpackage

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int REGION_BYTES = 8192,
  parameter int GAP_CYCLES = 100,
  parameter int POLL_LIMIT = 1000000,
  localparam int IDX_W = $clog2(REGION_BYTES),
  localparam int GAP_W = $clog2(GAP_CYCLES + 1),
  localparam int POLL_W = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              modeProgram,
  input  logic [7:0]        rdData,
  input  logic [7:0]        srcData,
  output logic [IDX_W-1:0]  byteIdx,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData,
  output logic              cmdDone,
  output logic              gapDone,
  output logic              pollLast,
  output logic              pairEqual,
  output logic              idxLast,
  output logic              verifyMatch
);

  localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'('h2AA);

  logic [2:0]        cmdIdx;
  logic [GAP_W-1:0]  gapCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [7:0]        firstRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdIdx    <= '0;
      byteIdx   <= '0;
      gapCnt    <= '0;
      pollCnt   <= '0;
      firstRead <= '0;
    end else begin
      if (strb.cmdClr)      cmdIdx <= '0;
      else if (strb.cmdInc) cmdIdx <= cmdIdx + 3'd1;
      if (strb.idxClr)      byteIdx <= '0;
      else if (strb.idxInc) byteIdx <= byteIdx + 1'b1;
      if (strb.gapLoad)     gapCnt <= GAP_W'(GAP_CYCLES - 1);
      else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (strb.pollClr)     pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (strb.capFirst)    firstRead <= rdData;
    end
  end

  // Command list selected by mode; the program list ends in the data write.
  always_comb begin
    cmdAddr = OFS_A;
    cmdData = CMD_UNLOCK_A;
    unique case (cmdIdx)
      3'd0: begin cmdAddr = OFS_A; cmdData = CMD_UNLOCK_A; end
      3'd1: begin cmdAddr = OFS_B; cmdData = CMD_UNLOCK_B; end
      3'd2: begin cmdAddr = OFS_A; cmdData = modeProgram ? CMD_PROGRAM : CMD_ERASE_PRE; end
      3'd3: begin
        if (modeProgram) begin
          cmdAddr = ADDR_W'(byteIdx);
          cmdData = srcData;
        end else begin
          cmdAddr = OFS_A;
          cmdData = CMD_UNLOCK_A;
        end
      end
      3'd4: begin cmdAddr = OFS_B; cmdData = CMD_UNLOCK_B; end
      default: begin cmdAddr = '0; cmdData = CMD_ERASE_GO; end
    endcase
  end

  assign cmdDone     = (cmdIdx == (modeProgram ? 3'd4 : 3'd6));
  assign gapDone     = (gapCnt == '0);
  assign pollLast    = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign pairEqual   = (rdData == firstRead);
  assign idxLast     = (byteIdx == IDX_W'(REGION_BYTES - 1));
  assign verifyMatch = (rdData == (modeProgram ? srcData : 8'hFF));

endmodule

// File: rtl/fseq_control.sv
module fseq_control
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IDX_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeIn,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              cmdDone,
  input  logic              gapDone,
  input  logic              pollLast,
  input  logic              pairEqual,
  input  logic              idxLast,
  input  logic              verifyMatch,
  output dpStrobe_t         strb,
  output logic              modeReg,
  output errCode_t          errCode,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashWrData,
  output logic              flashWe,
  output logic              flashRe
);

  seqState_t state, nextState;
  errCode_t  errNext;
  logic      modeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errCode <= ERR_NONE;
      modeReg <= 1'b0;
    end else begin
      state   <= nextState;
      errCode <= errNext;
      modeReg <= modeNext;
    end
  end

  always_comb begin
    strb        = '0;
    nextState   = state;
    errNext     = errCode;
    modeNext    = modeReg;
    flashWe     = 1'b0;
    flashRe     = 1'b0;
    flashAddr   = '0;
    flashWrData = '0;
    done        = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        modeNext     = modeIn;
        errNext      = ERR_NONE;
        strb.idxClr  = 1'b1;
        strb.cmdClr  = 1'b1;
        nextState    = ST_CMD;
      end
      ST_CMD: begin
        flashWe      = 1'b1;
        flashAddr    = cmdAddr;
        flashWrData  = cmdData;
        strb.gapLoad = 1'b1;
        strb.cmdInc  = 1'b1;
        nextState    = ST_GAP;
      end
      ST_GAP: if (gapDone) begin
        if (cmdDone) begin
          strb.pollClr = 1'b1;
          nextState    = ST_POLL_A;
        end else begin
          nextState = ST_CMD;
        end
      end
      ST_POLL_A: begin
        flashRe       = 1'b1;
        strb.capFirst = 1'b1;
        nextState     = ST_POLL_B;
      end
      ST_POLL_B: begin
        flashRe = 1'b1;
        if (pairEqual) begin
          if (modeReg && !idxLast) begin
            strb.idxInc = 1'b1;
            strb.cmdClr = 1'b1;
            nextState   = ST_CMD;
          end else begin
            nextState = ST_RST_CMD;
          end
        end else if (pollLast) begin
          errNext   = ERR_TIMEOUT;
          nextState = ST_RST_CMD;
        end else begin
          strb.pollInc = 1'b1;
          nextState    = ST_POLL_A;
        end
      end
      ST_RST_CMD: begin
        flashWe      = 1'b1;
        flashWrData  = CMD_RESET;
        strb.gapLoad = 1'b1;
        nextState    = ST_RST_GAP;
      end
      ST_RST_GAP: if (gapDone) begin
        if (errCode != ERR_NONE) begin
          nextState = ST_FINISH;
        end else begin
          strb.idxClr = 1'b1;
          nextState   = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        flashRe   = 1'b1;
        flashAddr = ADDR_W'(byteIdx);
        if (!verifyMatch) begin
          errNext   = ERR_VERIFY;
          nextState = ST_FINISH;
        end else if (idxLast) begin
          nextState = ST_FINISH;
        end else begin
          strb.idxInc = 1'b1;
        end
      end
      ST_FINISH: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/unlock_flash_seq.sv
module unlock_flash_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int REGION_BYTES = 8192,
  parameter int GAP_CYCLES = 100,
  parameter int POLL_LIMIT = 1000000,
  localparam int IDX_W = $clog2(REGION_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeProgram,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [1:0]        errCode,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashWrData,
  output logic              flashWe,
  output logic              flashRe,
  input  logic [7:0]        flashRdData,
  output logic [IDX_W-1:0]  srcAddr,
  input  logic [7:0]        srcData
);

  dpStrobe_t         strb;
  errCode_t          errState;
  logic              modeReg;
  logic [IDX_W-1:0]  byteIdx;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;
  logic              cmdDone, gapDone, pollLast, pairEqual, idxLast, verifyMatch;

  fseq_datapath #(
    .ADDR_W(ADDR_W), .REGION_BYTES(REGION_BYTES),
    .GAP_CYCLES(GAP_CYCLES), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeProgram(modeReg),
    .rdData(flashRdData), .srcData(srcData), .byteIdx(byteIdx),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdDone(cmdDone),
    .gapDone(gapDone), .pollLast(pollLast), .pairEqual(pairEqual),
    .idxLast(idxLast), .verifyMatch(verifyMatch)
  );

  fseq_control #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeProgram),
    .byteIdx(byteIdx), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdDone(cmdDone), .gapDone(gapDone), .pollLast(pollLast),
    .pairEqual(pairEqual), .idxLast(idxLast), .verifyMatch(verifyMatch),
    .strb(strb), .modeReg(modeReg), .errCode(errState), .busy(busy),
    .done(done), .flashAddr(flashAddr), .flashWrData(flashWrData),
    .flashWe(flashWe), .flashRe(flashRe)
  );

  assign srcAddr = byteIdx;
  assign errCode = errState;
  assign error   = (errState != ERR_NONE);

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        errCode,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [7:0]        flashWrData,
  input logic              flashWe,
  input logic              flashRe
);

  AST_UNLOCK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (flashWe && flashAddr == ADDR_W'('h555) && flashWrData == 8'hAA)); // R1

  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    flashWe |=> (!flashWe && !flashRe)); // R4

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R10

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(errCode)); // R10

  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    errCode != 2'd3); // R6

endmodule

bind unlock_flash_seq fseq_checker #(.ADDR_W(ADDR_W)) u_fseq_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .errCode(errCode), .flashAddr(flashAddr), .flashWrData(flashWrData),
  .flashWe(flashWe), .flashRe(flashRe)
);

// File: tb/test_unlock_flash_seq.sv
module test_unlock_flash_seq;

  localparam int ADDR_W = 11;
  localparam int REGION = 8;
  localparam int GAP = 3;
  localparam int PLIM = 6;
  localparam int IDX_W = $clog2(REGION);
  localparam int MSZ = 2 ** ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic modeProgram = 1'b0;
  logic busy, done, error, flashWe, flashRe;
  logic [1:0] errCode;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0] flashWrData, flashRdData, srcData;
  logic [IDX_W-1:0] srcAddr;

  always #2 clk = ~clk;

  unlock_flash_seq #(
    .ADDR_W(ADDR_W), .REGION_BYTES(REGION), .GAP_CYCLES(GAP), .POLL_LIMIT(PLIM)
  ) i_unlock_flash_seq (
    .clk(clk), .rstN(rstN), .start(start), .modeProgram(modeProgram),
    .busy(busy), .done(done), .error(error), .errCode(errCode),
    .flashAddr(flashAddr), .flashWrData(flashWrData), .flashWe(flashWe),
    .flashRe(flashRe), .flashRdData(flashRdData), .srcAddr(srcAddr),
    .srcData(srcData)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 37);
  endfunction

  logic [7:0] curSeed = 8'h00;
  assign srcData = pat(curSeed, int'(srcAddr));

  // Flash model: programming clears bits only, erase sets all ones.
  logic [7:0] mem [MSZ];
  int  busyLeft = 0, busyCfg = 0, stallAt = 0, seqPos = 0;
  int  cyc = 0, lastWr = -100;
  int  protoErrs = 0, gapErrs = 0, resetWrites = 0, progWrites = 0, readsAfterReset = 0;
  logic tog = 1'b0;
  logic weakEn = 1'b0;
  int  weakIdx = 0;

  initial for (int k = 0; k < MSZ; k++) mem[k] = 8'hFF;

  assign flashRdData = (busyLeft > 0) ? (tog ? 8'h40 : 8'h00) : mem[flashAddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if ((flashWe || flashRe) && (cyc - lastWr) <= GAP) gapErrs <= gapErrs + 1;
    if (flashWe) begin
      lastWr <= cyc;
      if (flashWrData == 8'hF0 && flashAddr == '0) begin
        resetWrites <= resetWrites + 1;
        busyLeft <= 0;
        seqPos <= 0;
        readsAfterReset <= 0;
      end else if (busyLeft > 0) begin
        protoErrs <= protoErrs + 1;
      end else begin
        seqPos <= 0;
        case (seqPos)
          0: if (flashAddr == 11'h555 && flashWrData == 8'hAA) seqPos <= 1; else protoErrs <= protoErrs + 1;
          1: if (flashAddr == 11'h2AA && flashWrData == 8'h55) seqPos <= 2; else protoErrs <= protoErrs + 1;
          2: if (flashAddr == 11'h555 && flashWrData == 8'h80) seqPos <= 3;
             else if (flashAddr == 11'h555 && flashWrData == 8'hA0) seqPos <= 6;
             else protoErrs <= protoErrs + 1;
          3: if (flashAddr == 11'h555 && flashWrData == 8'hAA) seqPos <= 4; else protoErrs <= protoErrs + 1;
          4: if (flashAddr == 11'h2AA && flashWrData == 8'h55) seqPos <= 5; else protoErrs <= protoErrs + 1;
          5: if (flashAddr == '0 && flashWrData == 8'h30) begin
               for (int k = 0; k < MSZ; k++) if (!(weakEn && k == weakIdx)) mem[k] <= 8'hFF;
               busyLeft <= busyCfg;
             end else protoErrs <= protoErrs + 1;
          6: begin
               mem[flashAddr] <= mem[flashAddr] & flashWrData;
               progWrites <= progWrites + 1;
               busyLeft <= (progWrites + 1 == stallAt) ? 1000000000 : busyCfg;
             end
          default: protoErrs <= protoErrs + 1;
        endcase
      end
    end else if (flashRe) begin
      readsAfterReset <= readsAfterReset + 1;
      if (busyLeft > 0) begin
        busyLeft <= busyLeft - 1;
        tog <= ~tog;
      end
    end
  end

  int checks = 0, errors = 0;
  int protoB, gapB, resetB, progB;
  int doneSeen;
  logic timedOut = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Run one operation; pokeAt>0 pulses a second start of the other mode mid-operation.
  task automatic doOp(input logic m, input logic [7:0] sd, input int bz, input int pokeAt);
    int n;
    busyCfg = bz;
    curSeed = sd;
    protoB = protoErrs; gapB = gapErrs; resetB = resetWrites; progB = progWrites;
    doneSeen = 0;
    @(negedge clk);
    start = 1'b1; modeProgram = m;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == pokeAt) begin
        start = 1'b1; modeProgram = ~m;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (n >= 20000) begin
      timedOut = 1'b1;
      check(1'b0, "watchdog op", n, 0);
    end
    doneSeen = 1;
    @(negedge clk);
    check(!done && !busy, "R10 done single pulse", int'({done, busy}), 0);
  endtask

  task automatic checkOp(input logic m, input logic [7:0] sd, input int expErr);
    logic imgOk;
    check(int'(errCode) == expErr, "R5 R6 R8 errCode", int'(errCode), expErr);
    check(error == (expErr != 0), "R10 error flag", int'(error), int'(expErr != 0));
    check(protoErrs == protoB, "R1 R2 R3 command protocol", protoErrs - protoB, 0);
    check(gapErrs == gapB, "R4 settling gap", gapErrs - gapB, 0);
    check(resetWrites == resetB + 1, "R7 one reset write", resetWrites - resetB, 1);
    if (expErr == 1)
      check(readsAfterReset == 0, "R6 no read-back after timeout", readsAfterReset, 0);
    if (expErr == 0) begin
      check(readsAfterReset == REGION, "R8 full read-back", readsAfterReset, REGION);
      imgOk = 1'b1;
      for (int k = 0; k < REGION; k++)
        if (mem[k] != (m ? pat(sd, k) : 8'hFF)) imgOk = 1'b0;
      check(imgOk, "R2 R3 flash image", int'(imgOk), 1);
      if (m) check(progWrites - progB == REGION, "R3 byte writes", progWrites - progB, REGION);
    end
    repeat (3) @(negedge clk);
    check(int'(errCode) == expErr, "R10 errCode held", int'(errCode), expErr);
  endtask

  // {mode, seed, busy reads, expected errCode}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'h00, 8'd4,  8'd0},
    {8'd1, 8'h3C, 8'd2,  8'd0},
    {8'd1, 8'h3C, 8'd0,  8'd0},
    {8'd1, 8'hC3, 8'd2,  8'd2},
    {8'd0, 8'h00, 8'd10, 8'd0},
    {8'd1, 8'hC3, 8'd10, 8'd0},
    {8'd0, 8'h00, 8'd12, 8'd1},
    {8'd0, 8'h00, 8'd0,  8'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !flashWe && !flashRe && errCode == 2'd0,
          "R9 in reset", int'({busy, done, error, flashWe, flashRe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !flashWe && !flashRe && errCode == 2'd0,
          "R9 after reset", int'({busy, done, error, flashWe, flashRe}), 0);

    for (int v = 0; v < 8; v++) begin
      doOp(VEC[v][24], VEC[v][23:16], int'(VEC[v][15:8]), 0);
      checkOp(VEC[v][24], VEC[v][23:16], int'(VEC[v][1:0]));
    end

    // R10: a start during an erase is ignored
    doOp(1'b0, 8'h00, 4, 10);
    checkOp(1'b0, 8'h00, 0);
    check(progWrites == progB, "R10 start while busy ignored", progWrites - progB, 0);

    // R6: timeout on the third byte aborts the remaining bytes
    stallAt = progWrites + 3;
    doOp(1'b1, 8'h5A, 2, 0);
    checkOp(1'b1, 8'h5A, 1);
    check(progWrites - progB == 3, "R6 program aborted", progWrites - progB, 3);
    stallAt = 0;

    // R8: erase leaving one byte unerased fails verify
    doOp(1'b0, 8'h00, 2, 0);
    checkOp(1'b0, 8'h00, 0);
    doOp(1'b1, 8'h3C, 2, 0);
    checkOp(1'b1, 8'h3C, 0);
    weakEn = 1'b1; weakIdx = 5;
    doOp(1'b0, 8'h00, 2, 0);
    checkOp(1'b0, 8'h00, 2);
    weakEn = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule